// File: doc/BRIEF.md
# Programmable Line Glitch Filter

This block cleans the level of an asynchronous, open-drain single-wire bus before a protocol decoder reads it. The raw line first passes through a two-flop synchronizer. A level change then reaches the output only after the synchronized input has stayed at the new level for a programmable span: the delay value times three periods of a selected tick.

The tick comes from a divider chain that runs on the system clock. The fine tick fires every `BASE_DIV` clocks. The next tick fires every `FIRST_RATIO` fine ticks. The two coarsest ticks each multiply the period before them by `DECADE`. With a 24 MHz clock and the default parameters, the four taps give 125 ns, 1 us, 10 us and 100 us. A typical setup uses the 1 us tap with a delay value of 7. A delay value of zero makes the filter transparent. A software reset input forces the synchronizer, the tick chain and the filter back to their reset state.

Top module: `line_glitch_filter`

## Requirements
- R1: After `rst`, `line_clean` is 1, which is the bus idle level.
- R2: A one-cycle `soft_rst` sets `line_clean` to 1 and discards any partly counted level change, so a new change needs a full hold span counted from after the reset.
- R3: `tick_sel` = 0 selects the fine tick, which fires once every `BASE_DIV` clocks.
- R4: `tick_sel` = 1 selects a tick every `FIRST_RATIO` fine ticks. `tick_sel` = 2 multiplies that period by `DECADE`, and `tick_sel` = 3 multiplies it by `DECADE` once more. Each coarser tick fires only in a cycle in which the next finer tick also fires.
- R5: When `dly` is nonzero, the output keeps its level if the synchronized input differs from it for fewer than `dly`*3 selected ticks.
- R6: When `dly` is nonzero and the synchronized input differs from the output on `dly`*3 selected ticks in a row, the output takes the new level at the clock edge of the last of those ticks.
- R7: Whenever the synchronized input returns to the output level, the tick count so far is discarded.
- R8: When `dly` = 0, the output follows `line_raw` with a latency of three clock edges: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous active-high software reset of the whole filter state |
| line_raw | input | 1 | Asynchronous raw bus level |
| tick_sel | input | 2 | Time base select: 0 fine, 1 to 3 successively coarser |
| dly | input | 3 | Delay multiplier; the hold span is dly*3 ticks |
| line_clean | output | 1 | Filtered bus level |

## Verification
The bench builds the block with `BASE_DIV`=3, `FIRST_RATIO`=2 and `DECADE`=3. The coarsest tick then repeats every 54 clocks instead of 2400, so even a full 21-tick hold on the slowest tap takes about a thousand cycles. These values put the widest spans, mid-run changes of tap and delay, and a long random stream of pulses around each threshold within a short run. Directed pulses sit one tick below and well above each hold span, and the slowest tap is driven in the same way.

// File: rtl/glitch_pkg.sv
package glitch_pkg;

    typedef enum logic [1:0] {
        TAP_FINE   = 2'd0,
        TAP_MID    = 2'd1,
        TAP_SLOW   = 2'd2,
        TAP_SLOWER = 2'd3
    } tap_e;

    localparam int NUM_TAPS = 4;
    localparam int DLY_W    = 3;
    localparam int SPAN_MUL = 3;
    localparam int CNT_W    = $clog2(((1 << DLY_W) - 1) * SPAN_MUL + 1);

    typedef logic [CNT_W-1:0] span_t;

    typedef struct packed {
        logic  level;
        span_t seen;
    } filt_state_t;

    function automatic span_t hold_span(input logic [DLY_W-1:0] d);
        return span_t'(d) * span_t'(SPAN_MUL);
    endfunction

endpackage

// File: rtl/line_sync.sv
module line_sync (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [1:0] stages;

    always_ff @(posedge clk) begin
        if (rst) stages <= 2'b11;
        else     stages <= {stages[0], d};
    end

    assign q = stages[1];
endmodule

// File: rtl/tick_chain.sv
module tick_chain
    import glitch_pkg::*;
#(
    parameter int BASE_DIV    = 3,
    parameter int FIRST_RATIO = 8,
    parameter int DECADE      = 10
) (
    input  logic                clk,
    input  logic                rst,
    output logic [NUM_TAPS-1:0] ticks
);
    localparam int BW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

    logic [BW-1:0] base_cnt;

    always_ff @(posedge clk) begin
        if (rst)          base_cnt <= '0;
        else if (ticks[0]) base_cnt <= '0;
        else              base_cnt <= base_cnt + 1'b1;
    end

    assign ticks[0] = (base_cnt == BW'(BASE_DIV - 1));

    for (genvar i = 1; i < NUM_TAPS; i++) begin : g_stage
        localparam int RATIO = (i == 1) ? FIRST_RATIO : DECADE;
        localparam int SW    = (RATIO > 1) ? $clog2(RATIO) : 1;
        logic [SW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (rst) cnt <= '0;
            else if (ticks[i-1]) begin
                if (cnt == SW'(RATIO - 1)) cnt <= '0;
                else                       cnt <= cnt + 1'b1;
            end
        end

        assign ticks[i] = ticks[i-1] && (cnt == SW'(RATIO - 1));

        AST_TICK_NESTED: assert property (@(posedge clk) disable iff (rst)
            ticks[i] |-> ticks[i-1]); // R4
    end
endmodule

// File: rtl/level_filter.sv
module level_filter
    import glitch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    output logic             level
);
    filt_state_t st;
    span_t       target;

    assign target = hold_span(dly);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{level: 1'b1, seen: '0};
        end else if (din == st.level) begin
            st.seen <= '0;
        end else if (dly == '0) begin
            st.level <= din;
            st.seen  <= '0;
        end else if (tick) begin
            if ((st.seen + 1'b1) >= target) begin
                st.level <= din;
                st.seen  <= '0;
            end else begin
                st.seen <= st.seen + 1'b1;
            end
        end
    end

    assign level = st.level;

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> level); // R1

    AST_ZERO_DELAY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (dly == '0) |=> (level == $past(din))); // R8

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (rst)
        ((dly != '0) && !tick) |=> $stable(level)); // R5
endmodule

// File: rtl/line_glitch_filter.sv
module line_glitch_filter
    import glitch_pkg::*;
#(
    parameter int BASE_DIV    = 3,
    parameter int FIRST_RATIO = 8,
    parameter int DECADE      = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       soft_rst,
    input  logic       line_raw,
    input  logic [1:0] tick_sel,
    input  logic [2:0] dly,
    output logic       line_clean
);
    logic                rst_any;
    logic                line_sync_q;
    logic [NUM_TAPS-1:0] ticks;
    tap_e                tap;
    logic                tick_hit;

    assign rst_any  = rst | soft_rst;
    assign tap      = tap_e'(tick_sel);
    assign tick_hit = ticks[tap];

    line_sync u_sync (
        .clk (clk),
        .rst (rst_any),
        .d   (line_raw),
        .q   (line_sync_q)
    );

    tick_chain #(
        .BASE_DIV    (BASE_DIV),
        .FIRST_RATIO (FIRST_RATIO),
        .DECADE      (DECADE)
    ) u_ticks (
        .clk   (clk),
        .rst   (rst_any),
        .ticks (ticks)
    );

    level_filter u_filt (
        .clk   (clk),
        .rst   (rst_any),
        .din   (line_sync_q),
        .tick  (tick_hit),
        .dly   (dly),
        .level (line_clean)
    );

    AST_SOFT_RESET_IDLE: assert property (@(posedge clk)
        soft_rst |=> line_clean); // R2
endmodule

// File: tb/test_line_glitch_filter.sv
module test_line_glitch_filter;
    localparam int BD = 3;
    localparam int R1_RATIO = 2;
    localparam int DEC = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       soft_rst = 1'b0;
    logic       line_raw = 1'b1;
    logic [1:0] tick_sel = 2'd0;
    logic [2:0] dly = 3'd0;
    logic       line_clean;

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";
    bit started = 1'b0;

    // behavioural reference state
    int c0 = 0, c1 = 0, c2 = 0, c3 = 0;
    bit m1 = 1, m2 = 1, mlev = 1;
    int mseen = 0;

    always #5 clk = ~clk;

    line_glitch_filter #(
        .BASE_DIV(BD), .FIRST_RATIO(R1_RATIO), .DECADE(DEC)
    ) i_line_glitch_filter (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .line_raw(line_raw),
        .tick_sel(tick_sel), .dly(dly), .line_clean(line_clean)
    );

    always @(posedge clk) begin
        bit t0, t1, t2, t3, tk;
        started = 1'b1;
        if (rst || soft_rst) begin
            c0 = 0; c1 = 0; c2 = 0; c3 = 0;
            m1 = 1; m2 = 1; mlev = 1; mseen = 0;
        end else begin
            t0 = (c0 == BD - 1);
            t1 = t0 && (c1 == R1_RATIO - 1);
            t2 = t1 && (c2 == DEC - 1);
            t3 = t2 && (c3 == DEC - 1);
            case (tick_sel)
                2'd0: tk = t0;
                2'd1: tk = t1;
                2'd2: tk = t2;
                default: tk = t3;
            endcase
            if (m2 == mlev) mseen = 0;
            else if (dly == 0) begin mlev = m2; mseen = 0; end
            else if (tk) begin
                mseen++;
                if (mseen >= dly * 3) begin mlev = m2; mseen = 0; end
            end
            c0 = t0 ? 0 : c0 + 1;
            if (t0) c1 = (c1 == R1_RATIO - 1) ? 0 : c1 + 1;
            if (t1) c2 = (c2 == DEC - 1) ? 0 : c2 + 1;
            if (t2) c3 = (c3 == DEC - 1) ? 0 : c3 + 1;
            m2 = m1;
            m1 = line_raw;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            vectors++;
            if (line_clean !== mlev) begin
                miscompares++;
                $display("FAIL %s model: actual %b expected %b at %0t", cur_req, line_clean, mlev, $time);
            end
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s directed: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1500000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        chk("R1", line_clean, 1'b1);

        // R8: transparent, three-edge latency
        cur_req = "R8";
        dly = 0; tick_sel = 0;
        wait_n(2);
        line_raw = 1'b0;
        wait_n(2);
        chk("R8", line_clean, 1'b1);
        wait_n(1);
        chk("R8", line_clean, 1'b0);
        line_raw = 1'b1;
        wait_n(5);
        chk("R8", line_clean, 1'b1);

        // R3/R5/R6: fine tick, hold span of 3 ticks
        cur_req = "R5";
        dly = 1; tick_sel = 0;
        wait_n(4);
        line_raw = 1'b0; wait_n(4); line_raw = 1'b1;
        wait_n(15);
        chk("R5", line_clean, 1'b1);
        cur_req = "R6";
        line_raw = 1'b0; wait_n(30);
        chk("R6", line_clean, 1'b0);
        cur_req = "R3";
        line_raw = 1'b1; wait_n(4);
        chk("R3", line_clean, 1'b1 ^ 1'b1); // 4 clocks after change: at most one fine tick counted
        wait_n(20);
        chk("R3", line_clean, 1'b1);
        line_raw = 1'b0; wait_n(30);

        // R7: interrupted pulses never add up
        cur_req = "R7";
        dly = 2;
        for (int k = 0; k < 3; k++) begin
            line_raw = 1'b1; wait_n(12);
            line_raw = 1'b0; wait_n(1);
        end
        wait_n(10);
        chk("R7", line_clean, 1'b0);

        // R4: slowest tap
        cur_req = "R4";
        dly = 1; tick_sel = 3;
        line_raw = 1'b1; wait_n(100); line_raw = 1'b0;
        wait_n(20);
        chk("R4", line_clean, 1'b0);
        line_raw = 1'b1; wait_n(250);
        chk("R4", line_clean, 1'b1);
        for (int s = 1; s < 4; s++) begin
            tick_sel = 2'(s);
            for (int k = 0; k < 6; k++) begin
                line_raw = ~line_raw;
                wait_n(20 + 40 * k);
            end
        end

        // R2: software reset drops a partial count
        cur_req = "R2";
        tick_sel = 0; dly = 7; line_raw = 1'b1;
        wait_n(200);
        line_raw = 1'b0; wait_n(40);
        soft_rst = 1'b1; wait_n(1); soft_rst = 1'b0;
        chk("R2", line_clean, 1'b1);
        wait_n(40);
        chk("R2", line_clean, 1'b1);
        wait_n(60);
        chk("R2", line_clean, 1'b0);

        // random stream across taps and delays
        cur_req = "R6";
        for (int k = 0; k < 400; k++) begin
            if (k % 20 == 0) begin
                tick_sel = 2'($urandom_range(0, 3));
                dly = 3'($urandom_range(0, 7));
            end
            line_raw = ~line_raw;
            wait_n($urandom_range(1, 160));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule